// File: doc/BRIEF.md
# Keyed flash program/erase controller

This block sits between a CPU register bus and an embedded flash array. Software picks an operation code, turns on write enable, writes a fixed three-word unlock key and then sets the go bit. The go bit reads back as a busy flag until the operation ends, and then it drops by itself. The block supports two real operations. A word program merges new data into one array word. A page erase sets a whole page to ones. A no-operation command clears the sticky error flags. If the page is write-locked or the supply is reported low, the block raises a flag and never touches the array.

Each of the four registers (control, key, address, data) accepts a raw write, a set-bits write or a clear-bits write. The array is reached over a request channel with valid/ready handshaking. The controller holds a request and all its fields stable until the array takes it. The array answers a read with a one-cycle data strobe that may arrive any number of cycles later. Program and erase hold the busy flag for cycle counts set by parameters, so each software driver sees its own array timing.

Top module: `keyed_nvm_ctrl`

## Requirements
- R1: After reset the control, address and data readbacks and busy are all 0. reg_sel selects 0 = control, 1 = key, 2 = address, 3 = data. reg_view selects 0 = replace, 1 = OR in the written bits, 2 = clear the written bits, and 3 acts as replace.
- R2: The control readback has the operation code in bits 3:0, busy in bit 15, write enable in bit 14, the lock-error flag in bit 13 and the low-supply flag in bit 12. All other bits read 0. Code 0 is no-op, 1 is word program and 4 is page erase.
- R3: The unlock arms only after three key writes in a row: 0x00000000, then 0xAA996655, then 0x556699AA. A key write of zero always restarts the sequence at its first step. Any other mismatched key write, or any key write while armed, disarms the unlock.
- R4: A control write through the replace or set view whose written data has bit 15 = 1 starts an operation only if the resulting write-enable bit is 1, the unlock is armed and the block is idle. Any such write uses up the unlock, whether or not it starts an operation.
- R5: Busy reads 1 from the cycle after an accepted start until the operation ends, and then clears by itself. A software write cannot clear it.
- R6: A word program reads the addressed word, then writes back the old value ANDed with the data register. The word address is bits above 1 of the address register.
- R7: A page erase sets every word of the page that holds the address register to all ones. The page size is PAGE_BYTES.
- R8: If program or erase targets a page whose page_lock bit is 1, the lock-error flag is set. If supply_low is 1 when the operation is decoded, the low-supply flag is set. In both cases the array gets no request at all.
- R9: Starting a no-op clears both error flags.
- R10: While busy, writes to the address register, the data register and the operation code have no effect, and they are not applied later.
- R11: An array request holds fl_valid and all its fields stable until fl_ready is seen. A request is only raised while busy.
- R12: Busy falls exactly WORD_CYCLES (program) or ERASE_CYCLES (erase) cycles after the clock edge that completes the program or erase handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_view | input | 2 | Write view: replace, set, clear |
| reg_wdata | input | 32 | Register write data |
| rd_ctrl | output | 32 | Control/status readback |
| rd_addr | output | 32 | Address register readback |
| rd_data | output | 32 | Data register readback |
| busy | output | 1 | Operation in progress |
| page_lock | input | NUM_PAGES | Per-page write lock |
| supply_low | input | 1 | Low supply indication |
| fl_valid | output | 1 | Array request valid |
| fl_ready | input | 1 | Array accepts request |
| fl_op | output | 2 | Request kind: 0 read, 1 program, 2 erase page |
| fl_addr | output | log2(PAGE_BYTES*NUM_PAGES)-2 | Word address (page base for erase) |
| fl_wdata | output | 32 | Program data |
| fl_rvalid | input | 1 | Read data strobe |
| fl_rdata | input | 32 | Read data |

## Verification
The bench builds the block with 32-byte pages, four pages, a 4-cycle program and a 20-cycle erase. With that small array, every word can be programmed twice, every page erased, and every pairing of locked page and erased page tried. The whole array is compared against an arithmetic model after each operation. The short durations let the bench measure the exact busy length of every operation while the array ready pattern stalls requests. The 20-cycle erase leaves enough time to try the ignored writes and a clear of the busy flag in the middle of an operation. The bench also sweeps several correct and broken key sequences.

// File: rtl/knc_pkg.sv
package knc_pkg;

  localparam int unsigned CTRL_GO    = 15;
  localparam int unsigned CTRL_WEN   = 14;
  localparam int unsigned CTRL_WERR  = 13;
  localparam int unsigned CTRL_LVERR = 12;

  localparam logic [3:0] OPC_NOP  = 4'd0;
  localparam logic [3:0] OPC_WORD = 4'd1;
  localparam logic [3:0] OPC_PAGE = 4'd4;

  localparam logic [31:0] KEY_ZERO = 32'h0000_0000;
  localparam logic [31:0] KEY_ONE  = 32'hAA99_6655;
  localparam logic [31:0] KEY_TWO  = 32'h5566_99AA;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_KEY  = 2'd1;
  localparam logic [1:0] SEL_ADDR = 2'd2;
  localparam logic [1:0] SEL_DATA = 2'd3;

  localparam logic [1:0] VIEW_RAW = 2'd0;
  localparam logic [1:0] VIEW_SET = 2'd1;
  localparam logic [1:0] VIEW_CLR = 2'd2;

  localparam logic [1:0] FL_READ  = 2'd0;
  localparam logic [1:0] FL_PROG  = 2'd1;
  localparam logic [1:0] FL_ERASE = 2'd2;

  // Combine a register's current value with written data per view.
  function automatic logic [31:0] apply_view(input logic [31:0] cur,
                                             input logic [31:0] wd,
                                             input logic [1:0]  view);
    case (view)
      VIEW_SET: return cur | wd;
      VIEW_CLR: return cur & ~wd;
      default:  return wd;
    endcase
  endfunction

endpackage

// File: rtl/knc_unlock.sv
module knc_unlock
  import knc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr,
  input  logic [31:0] key_val,
  input  logic        consume,
  output logic        armed
);

  typedef enum logic [1:0] {K_IDLE, K_GOT0, K_GOT1, K_ARMED} kstage_e;
  kstage_e stage;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage <= K_IDLE;
    end else if (consume) begin
      stage <= K_IDLE;
    end else if (key_wr) begin
      if (key_val == KEY_ZERO)
        stage <= K_GOT0;
      else if (stage == K_GOT0 && key_val == KEY_ONE)
        stage <= K_GOT1;
      else if (stage == K_GOT1 && key_val == KEY_TWO)
        stage <= K_ARMED;
      else
        stage <= K_IDLE;
    end
  end

  assign armed = (stage == K_ARMED);

endmodule

// File: rtl/knc_sequencer.sv
module knc_sequencer
  import knc_pkg::*;
#(
  parameter int unsigned PAGE_BYTES   = 16384,
  parameter int unsigned NUM_PAGES    = 64,
  parameter int unsigned WORD_CYCLES  = 40,
  parameter int unsigned ERASE_CYCLES = 400,
  localparam int unsigned ADDR_W   = $clog2(PAGE_BYTES * NUM_PAGES),
  localparam int unsigned WORD_AW  = ADDR_W - 2,
  localparam int unsigned PAGE_WSH = $clog2(PAGE_BYTES / 4),
  localparam int unsigned MAXC     = (ERASE_CYCLES > WORD_CYCLES) ? ERASE_CYCLES : WORD_CYCLES,
  localparam int unsigned CW       = $clog2(MAXC + 1)
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [3:0]           op,
  input  logic [WORD_AW-1:0]   tgt_addr,
  input  logic [31:0]          tgt_data,
  input  logic [NUM_PAGES-1:0] page_lock,
  input  logic                 supply_low,
  output logic                 busy,
  output logic                 err_lock,
  output logic                 err_volt,
  output logic                 fl_valid,
  input  logic                 fl_ready,
  output logic [1:0]           fl_op,
  output logic [WORD_AW-1:0]   fl_addr,
  output logic [31:0]          fl_wdata,
  input  logic                 fl_rvalid,
  input  logic [31:0]          fl_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_DECIDE, S_RD_REQ, S_RD_WAIT,
                            S_PG_REQ, S_ER_REQ, S_HOLD} sstate_e;

  sstate_e              st;
  logic [3:0]           cur_op;
  logic [CW-1:0]        hold_cnt;
  logic [31:0]          merged;
  logic [WORD_AW-PAGE_WSH-1:0] pg;
  logic [WORD_AW-1:0]   page_base;

  assign pg        = tgt_addr[WORD_AW-1:PAGE_WSH];
  assign page_base = {pg, {PAGE_WSH{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_op   <= OPC_NOP;
      hold_cnt <= '0;
      merged   <= '0;
      err_lock <= 1'b0;
      err_volt <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          cur_op <= op;
          st     <= S_DECIDE;
        end
        S_DECIDE: begin
          st <= S_IDLE;
          if (cur_op == OPC_NOP) begin
            err_lock <= 1'b0;
            err_volt <= 1'b0;
          end else if (cur_op == OPC_WORD || cur_op == OPC_PAGE) begin
            if (page_lock[pg])
              err_lock <= 1'b1;
            else if (supply_low)
              err_volt <= 1'b1;
            else
              st <= (cur_op == OPC_WORD) ? S_RD_REQ : S_ER_REQ;
          end
        end
        S_RD_REQ:  if (fl_ready) st <= S_RD_WAIT;
        S_RD_WAIT: if (fl_rvalid) begin
          merged <= fl_rdata & tgt_data;
          st     <= S_PG_REQ;
        end
        S_PG_REQ: if (fl_ready) begin
          hold_cnt <= CW'(WORD_CYCLES - 1);
          st       <= S_HOLD;
        end
        S_ER_REQ: if (fl_ready) begin
          hold_cnt <= CW'(ERASE_CYCLES - 1);
          st       <= S_HOLD;
        end
        S_HOLD: begin
          if (hold_cnt == '0) st <= S_IDLE;
          else                hold_cnt <= hold_cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    fl_valid = 1'b0;
    fl_op    = FL_READ;
    fl_addr  = tgt_addr;
    case (st)
      S_RD_REQ: fl_valid = 1'b1;
      S_PG_REQ: begin fl_valid = 1'b1; fl_op = FL_PROG; end
      S_ER_REQ: begin fl_valid = 1'b1; fl_op = FL_ERASE; fl_addr = page_base; end
      default: ;
    endcase
  end

  assign fl_wdata = merged;
  assign busy     = (st != S_IDLE);

endmodule

// File: rtl/keyed_nvm_ctrl.sv
module keyed_nvm_ctrl
  import knc_pkg::*;
#(
  parameter int unsigned PAGE_BYTES   = 16384,
  parameter int unsigned NUM_PAGES    = 64,
  parameter int unsigned WORD_CYCLES  = 40,
  parameter int unsigned ERASE_CYCLES = 400,
  localparam int unsigned ADDR_W  = $clog2(PAGE_BYTES * NUM_PAGES),
  localparam int unsigned WORD_AW = ADDR_W - 2
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [1:0]           reg_sel,
  input  logic [1:0]           reg_view,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          rd_ctrl,
  output logic [31:0]          rd_addr,
  output logic [31:0]          rd_data,
  output logic                 busy,
  input  logic [NUM_PAGES-1:0] page_lock,
  input  logic                 supply_low,
  output logic                 fl_valid,
  input  logic                 fl_ready,
  output logic [1:0]           fl_op,
  output logic [WORD_AW-1:0]   fl_addr,
  output logic [31:0]          fl_wdata,
  input  logic                 fl_rvalid,
  input  logic [31:0]          fl_rdata
);

  logic [31:0] addr_q, data_q;
  logic [3:0]  op_q;
  logic        wen_q;
  logic        err_lock, err_volt;
  logic        key_armed;
  logic        wr_ctrl, go_req, start_go;
  logic [31:0] ctrl_nv;
  logic        unused_ctrl_bits;

  assign wr_ctrl  = reg_wr && (reg_sel == SEL_CTRL);
  assign ctrl_nv  = apply_view(rd_ctrl, reg_wdata, reg_view);
  assign go_req   = wr_ctrl && (reg_view != VIEW_CLR) && reg_wdata[CTRL_GO];
  assign start_go = go_req && !busy && ctrl_nv[CTRL_WEN] && key_armed;
  assign unused_ctrl_bits = ^{ctrl_nv[31:15], ctrl_nv[13:4]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      op_q   <= OPC_NOP;
      wen_q  <= 1'b0;
    end else begin
      if (reg_wr && reg_sel == SEL_ADDR && !busy)
        addr_q <= apply_view(addr_q, reg_wdata, reg_view);
      if (reg_wr && reg_sel == SEL_DATA && !busy)
        data_q <= apply_view(data_q, reg_wdata, reg_view);
      if (wr_ctrl) begin
        wen_q <= ctrl_nv[CTRL_WEN];
        if (!busy) op_q <= ctrl_nv[3:0];
      end
    end
  end

  knc_unlock u_unlock (
    .clk     (clk),
    .rst_n   (rst_n),
    .key_wr  (reg_wr && (reg_sel == SEL_KEY)),
    .key_val (reg_wdata),
    .consume (go_req),
    .armed   (key_armed)
  );

  knc_sequencer #(
    .PAGE_BYTES   (PAGE_BYTES),
    .NUM_PAGES    (NUM_PAGES),
    .WORD_CYCLES  (WORD_CYCLES),
    .ERASE_CYCLES (ERASE_CYCLES)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_go),
    .op         (ctrl_nv[3:0]),
    .tgt_addr   (addr_q[ADDR_W-1:2]),
    .tgt_data   (data_q),
    .page_lock  (page_lock),
    .supply_low (supply_low),
    .busy       (busy),
    .err_lock   (err_lock),
    .err_volt   (err_volt),
    .fl_valid   (fl_valid),
    .fl_ready   (fl_ready),
    .fl_op      (fl_op),
    .fl_addr    (fl_addr),
    .fl_wdata   (fl_wdata),
    .fl_rvalid  (fl_rvalid),
    .fl_rdata   (fl_rdata)
  );

  assign rd_ctrl = {16'h0000, busy, wen_q, err_lock, err_volt, 8'h00, op_q};
  assign rd_addr = addr_q;
  assign rd_data = data_q;

endmodule

// File: rtl/knc_checker.sv
module knc_checker
  import knc_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 16384,
  parameter int unsigned NUM_PAGES  = 64,
  localparam int unsigned ADDR_W   = $clog2(PAGE_BYTES * NUM_PAGES),
  localparam int unsigned WORD_AW  = ADDR_W - 2,
  localparam int unsigned PAGE_WSH = $clog2(PAGE_BYTES / 4)
)(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 busy,
  input logic                 key_armed,
  input logic                 fl_valid,
  input logic                 fl_ready,
  input logic [1:0]           fl_op,
  input logic [WORD_AW-1:0]   fl_addr,
  input logic [31:0]          fl_wdata,
  input logic [31:0]          rd_addr,
  input logic [31:0]          rd_data,
  input logic [NUM_PAGES-1:0] page_lock
);

  // R4: busy only rises when the unlock was armed in the start cycle
  a_r4_start_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(key_armed));

  // R11: a stalled request keeps its fields
  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid && !fl_ready |=> fl_valid && $stable(fl_op) && $stable(fl_addr) && $stable(fl_wdata));

  // R11: requests only inside an operation
  a_r11_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid |-> busy);

  // R6: programmed value never sets a bit the data register has clear
  a_r6_prog_clears_only: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid && fl_op == FL_PROG |-> (fl_wdata & ~rd_data) == 32'h0);

  // R8: locked pages never see a program or erase request
  a_r8_locked_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid && fl_op != FL_READ |-> !page_lock[fl_addr[WORD_AW-1:PAGE_WSH]]);

  // R10: address and data registers frozen across busy cycles
  a_r10_regs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(rd_addr) && $stable(rd_data));

endmodule

bind keyed_nvm_ctrl knc_checker #(
  .PAGE_BYTES (PAGE_BYTES),
  .NUM_PAGES  (NUM_PAGES)
) u_knc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .key_armed (key_armed),
  .fl_valid  (fl_valid),
  .fl_ready  (fl_ready),
  .fl_op     (fl_op),
  .fl_addr   (fl_addr),
  .fl_wdata  (fl_wdata),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .page_lock (page_lock)
);

// File: tb/test_keyed_nvm_ctrl.sv
`timescale 1ns/1ps
module test_keyed_nvm_ctrl;

  localparam int PB = 32;
  localparam int NP = 4;
  localparam int WC = 4;
  localparam int EC = 20;
  localparam int NW = PB * NP / 4;
  localparam int PW = PB / 4;
  localparam int AW = $clog2(PB * NP) - 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_sel = '0, reg_view = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   rd_ctrl, rd_addr, rd_data;
  logic          busy;
  logic [NP-1:0] page_lock = '0;
  logic          supply_low = 1'b0;
  logic          fl_valid, fl_ready;
  logic [1:0]    fl_op;
  logic [AW-1:0] fl_addr;
  logic [31:0]   fl_wdata;
  logic          fl_rvalid;
  logic [31:0]   fl_rdata;

  always #2.5 clk = ~clk;

  keyed_nvm_ctrl #(.PAGE_BYTES(PB), .NUM_PAGES(NP), .WORD_CYCLES(WC), .ERASE_CYCLES(EC))
  i_keyed_nvm_ctrl (.*);

  int n_run = 0, n_fail = 0;
  bit done = 0;
  int cyc = 0;
  int hs_cyc = 0, fall_cyc = 0, acc_cnt = 0;
  logic prev_busy = 1'b0;
  logic [31:0] mem [NW];
  logic [31:0] exp_m [NW];

  always @(posedge clk) cyc <= cyc + 1;
  assign fl_ready = (cyc % 3) != 1;

  // behavioural array
  always @(posedge clk) begin
    fl_rvalid <= 1'b0;
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) mem[i] <= (i * 32'h9E37_79B9) ^ 32'h0001_3570;
      fl_rdata <= '0;
    end else if (fl_valid && fl_ready) begin
      case (fl_op)
        2'd0: begin fl_rvalid <= 1'b1; fl_rdata <= mem[fl_addr]; end
        2'd1: mem[fl_addr] <= fl_wdata;
        default: for (int i = 0; i < PW; i++) mem[int'(fl_addr) + i] <= 32'hFFFF_FFFF;
      endcase
    end
  end

  always @(negedge clk) begin
    if (prev_busy && !busy) fall_cyc = cyc;
    prev_busy = busy;
    if (fl_valid && fl_ready) begin
      acc_cnt++;
      if (fl_op != 2'd0) hs_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [1:0] view, input logic [31:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_view = view; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic unlock();
    wr(2'd1, 2'd0, 32'h0000_0000);
    wr(2'd1, 2'd0, 32'hAA99_6655);
    wr(2'd1, 2'd0, 32'h5566_99AA);
  endtask

  task automatic wait_idle(input string req);
    int t = 0;
    while (busy && t < 500) begin @(negedge clk); t++; end
    if (busy) chk(1'b0, req, {31'd0, busy}, 32'd0);
    @(negedge clk);
  endtask

  task automatic cmp_mem(input string req);
    int bad = -1;
    for (int i = 0; i < NW; i++) if (mem[i] !== exp_m[i] && bad < 0) bad = i;
    if (bad < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, mem[bad], exp_m[bad]);
  endtask

  task automatic start_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] d);
    wr(2'd2, 2'd0, a);
    wr(2'd3, 2'd0, d);
    wr(2'd0, 2'd0, {28'd0, op});
    wr(2'd0, 2'd1, 32'h0000_4000);
    unlock();
    wr(2'd0, 2'd1, 32'h0000_8000);
  endtask

  task automatic run(input logic [3:0] op, input logic [31:0] a, input logic [31:0] d,
                     input bit access, input string req);
    int acc0 = acc_cnt;
    int w = int'(a[AW+1:2]);
    int pbase = (w / PW) * PW;
    start_op(op, a, d);
    chk(busy === 1'b1, "R5 busy after start", {31'd0, busy}, 1);
    wait_idle("R5 busy never cleared");
    if (access) begin
      if (op == 4'd1) exp_m[w] = exp_m[w] & d;
      else for (int i = 0; i < PW; i++) exp_m[pbase + i] = 32'hFFFF_FFFF;
      chk(fall_cyc - hs_cyc == ((op == 4'd1) ? WC : EC) + 1, "R12 duration",
          fall_cyc - hs_cyc, ((op == 4'd1) ? WC : EC) + 1);
    end else begin
      chk(acc_cnt == acc0, "R8 no array access", acc_cnt, acc0);
    end
    cmp_mem(req);
  endtask

  task automatic key_try(input logic [31:0] k0, k1, k2, k3, input int n, input bit expect_go);
    logic [31:0] ks [4];
    ks[0] = k0; ks[1] = k1; ks[2] = k2; ks[3] = k3;
    wr(2'd0, 2'd0, 32'h0000_4000);
    for (int i = 0; i < n; i++) wr(2'd1, 2'd0, ks[i]);
    wr(2'd0, 2'd1, 32'h0000_8000);
    chk(busy === expect_go, "R3 key sequence", {31'd0, busy}, {31'd0, expect_go});
    wait_idle("R3 idle");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) exp_m[i] = (i * 32'h9E37_79B9) ^ 32'h0001_3570;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rd_ctrl == 0 && rd_addr == 0 && rd_data == 0 && !busy, "R1 reset", rd_ctrl, 0);
    cmp_mem("R1 array untouched");

    // R1 views
    wr(2'd2, 2'd0, 32'hF0F0_1234);
    wr(2'd2, 2'd1, 32'h0000_000F);
    chk(rd_addr == 32'hF0F0_123F, "R1 set view", rd_addr, 32'hF0F0_123F);
    wr(2'd2, 2'd2, 32'hF000_0003);
    chk(rd_addr == 32'h00F0_123C, "R1 clr view", rd_addr, 32'h00F0_123C);
    wr(2'd3, 2'd3, 32'h1357_9BDF);
    wr(2'd3, 2'd2, 32'h0000_00FF);
    chk(rd_data == 32'h1357_9B00, "R1 data views", rd_data, 32'h1357_9B00);
    // R2 layout
    wr(2'd0, 2'd0, 32'h0000_0004);
    wr(2'd0, 2'd1, 32'h0000_4000);
    chk(rd_ctrl == 32'h0000_4004, "R2 ctrl layout", rd_ctrl, 32'h0000_4004);
    wr(2'd0, 2'd2, 32'h0000_0004);
    chk(rd_ctrl == 32'h0000_4000, "R2 ctrl clr", rd_ctrl, 32'h0000_4000);

    // R7 erase each page
    for (int p = 0; p < NP; p++)
      run(4'd4, p * PB + ((p * 12) & 28), 32'h0, 1'b1, "R7 page erase");

    // R6 two program passes
    for (int w = 0; w < NW; w++)
      run(4'd1, w * 4, 32'hFFFF_0000 ^ (w * 32'h0101_0101), 1'b1, "R6 program pass1");
    for (int w = 0; w < NW; w++)
      run(4'd1, w * 4, ~(32'h1 << w), 1'b1, "R6 program pass2");

    // R3 key sequences
    key_try(32'h0, 32'hAA99_6655, 32'h5566_99AA, 32'h0, 3, 1'b1);
    key_try(32'hAA99_6655, 32'h5566_99AA, 32'h0, 32'h0, 2, 1'b0);
    key_try(32'h0, 32'h5566_99AA, 32'hAA99_6655, 32'h0, 3, 1'b0);
    key_try(32'h0, 32'hAA99_6655, 32'h1234, 32'h5566_99AA, 4, 1'b0);
    key_try(32'h0, 32'hAA99_6655, 32'h5566_99AA, 32'h5, 4, 1'b0);
    key_try(32'h0, 32'h0, 32'hAA99_6655, 32'h5566_99AA, 4, 1'b1);
    key_try(32'h0, 32'hAA99_6655, 32'h5566_99AA, 32'h0, 4, 1'b0);
    key_try(32'h5566_99AA, 32'h0, 32'hAA99_6655, 32'h5566_99AA, 4, 1'b1);

    // R4 write enable and consumption
    wr(2'd0, 2'd0, 32'h0);
    unlock();
    wr(2'd0, 2'd1, 32'h0000_8000);
    chk(!busy, "R4 no start without enable", {31'd0, busy}, 0);
    wr(2'd0, 2'd1, 32'h0000_4000);
    wr(2'd0, 2'd1, 32'h0000_8000);
    chk(!busy, "R4 unlock consumed", {31'd0, busy}, 0);
    unlock();
    wr(2'd0, 2'd0, 32'h0000_C000);
    chk(busy === 1'b1, "R4 enable and go together", {31'd0, busy}, 1);
    wait_idle("R4 idle");

    // R8/R9 lock sweep: lock page p, erase page q
    for (int p = 0; p < NP; p++) begin
      page_lock = NP'(1) << p;
      for (int q = 0; q < NP; q++) begin
        run(4'd4, q * PB + 4, 32'h0, (p != q), "R8 lock sweep");
        chk(rd_ctrl[13] == (p == q), "R8 lock flag", rd_ctrl, {18'd0, (p == q), 13'd0});
        run(4'd0, 32'h0, 32'h0, 1'b0, "R9 nop");
        chk(rd_ctrl[13:12] == 2'b00, "R9 nop clears", rd_ctrl, 0);
      end
    end
    page_lock = '0;
    run(4'd1, 32'h14, 32'h00FF_00FF, 1'b1, "R6 program after erase");
    page_lock = 4'b0001;
    run(4'd1, 32'h4, 32'h0, 1'b0, "R8 locked program");
    chk(rd_ctrl[13], "R8 program lock flag", rd_ctrl, 32'h2000);
    page_lock = '0;
    supply_low = 1'b1;
    run(4'd1, 32'h24, 32'h0, 1'b0, "R8 low supply");
    chk(rd_ctrl[13:12] == 2'b11, "R8 both flags sticky", rd_ctrl, 32'h3000);
    supply_low = 1'b0;
    run(4'd0, 32'h0, 32'h0, 1'b0, "R9 nop");
    chk(rd_ctrl[13:12] == 2'b00, "R9 flags cleared", rd_ctrl, 0);

    // R10/R5 writes during busy erase of page 1
    start_op(4'd4, 32'h28, 32'h0BAD_F00D);
    wr(2'd0, 2'd2, 32'h0000_8000);
    chk(busy === 1'b1, "R5 busy not clearable", {31'd0, busy}, 1);
    wr(2'd2, 2'd0, 32'h0000_007C);
    wr(2'd3, 2'd0, 32'h0);
    wr(2'd0, 2'd0, 32'h0000_0001);
    chk(busy === 1'b1, "R10 still busy", {31'd0, busy}, 1);
    wait_idle("R10 idle");
    for (int i = 0; i < PW; i++) exp_m[PW + i] = 32'hFFFF_FFFF;
    chk(rd_addr == 32'h28, "R10 addr ignored", rd_addr, 32'h28);
    chk(rd_data == 32'h0BAD_F00D, "R10 data ignored", rd_data, 32'h0BAD_F00D);
    chk(rd_ctrl[3:0] == 4'd4, "R10 op ignored", rd_ctrl, 32'h4);
    cmp_mem("R10 erase result");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule